// File: doc/BRIEF.md
# Sensor Interrupt Flag Controller

This block is the interrupt logic behind the register interface of a motion sensor. It receives strobes and levels from elsewhere in the sensor: a new-sample strobe, the empty and full levels of the 32-entry sample FIFO, a wake-detect strobe, and the current operating mode. From these it keeps two readable registers. The first is a status register with live levels, a sticky new-data bit and a pending summary bit. The second is a latched interrupt flag register. Each source is gated by a writable enable register.

Register reads arrive as a read strobe with an address. The read data is returned combinationally in the same cycle, and the clear-on-read side effect lands at the next clock edge. If a set event and a clearing read arrive in the same cycle, the event wins, so no event is lost.

An active-high interrupt pin is the registered OR of every flag that is also enabled. The pin is optional through a parameter.

Top module: `sensor_irq_ctrl`

## Requirements
- R1: After reset, with the FIFO empty input high, address 0x08 reads 0x10, addresses 0x09 and 0x17 read 0x00, and `int_o` is low.
- R2: A write to address 0x17 stores only bits 3, 4 and 5; the other bits read back as 0. Bit 3 enables both the wake source and the sample source, bit 4 enables the empty source, and bit 5 enables the full source. A source whose enable is 0 never latches its flag.
- R3: Address 0x08 reads as follows. Bit 3 is new-data. Bit 4 is the live FIFO empty level. Bit 5 is the live FIFO full level. Bit 7 is pending, which is 1 whenever any flag in 0x09 is set. All other bits read 0.
- R4: New-data sets on every sample strobe in any mode, with no enable. It clears on a read of 0x08. A read of 0x08 leaves the empty and full levels unchanged.
- R5: Address 0x09 holds these flags: wake at bit 2, sample at bit 3, empty at bit 4 and full at bit 5. A read returns the flags and then clears all of them.
- R6: The mode input is encoded 0 sleep, 1 standby, 2 sniff, 3 continuous wake, 4 triggered. The sample flag latches only in modes 3 and 4. Once it has been cleared by a read of 0x09, the next sample sets it again.
- R7: The empty flag sets only on a low-to-high change of the empty input. While the input stays high after a clearing read, the flag does not set again.
- R8: The full flag sets only on a low-to-high change of the full input. It does not set again until the input has dropped and risen again.
- R9: A wake strobe latches the wake flag.
- R10: If a flag-setting event and a clearing read of the same register arrive in the same cycle, the bit is set after that cycle. This holds for both 0x08 and 0x09.
- R11: `int_o` equals the OR over the sources of (flag AND its enable), taken one clock edge after the flags and enables change.
- R12: A read of any address other than 0x08, 0x09 or 0x17 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_evt_i | input | 1 | New sample strobe, one cycle |
| wake_evt_i | input | 1 | Wake-detect strobe, one cycle |
| fifo_empty_i | input | 1 | FIFO empty level (pointers equal) |
| fifo_full_i | input | 1 | FIFO full level (32 samples held) |
| mode_i | input | 3 | Operating mode code |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 8 | Read address |
| rd_data_o | output | 8 | Read data, valid in the strobe cycle |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Write address |
| wr_data_i | input | 8 | Write data |
| int_o | output | 1 | Interrupt pin, active high |

## Verification
Sample strobes are applied in every mode. The reads show that new-data ignores the mode while the sample flag latches only in continuous-wake and triggered modes, and that a second sample after a clearing read sets the flag again. The FIFO level inputs are driven through falls, rises and long holds, which separates edge-triggered flags from level-triggered ones. Strobes that coincide with clearing reads separate set-wins behaviour from clear-wins behaviour. The pin is sampled on the cycle of each flag or enable change and on the cycle after, which pins down its one-cycle delay and its masking by the enables.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  typedef enum logic [2:0] {
    MODE_SLEEP   = 3'd0,
    MODE_STANDBY = 3'd1,
    MODE_SNIFF   = 3'd2,
    MODE_CWAKE   = 3'd3,
    MODE_TRIG    = 3'd4
  } op_mode_e;

  // flag positions in the latched flag register
  localparam int unsigned FLG_WAKE  = 2;
  localparam int unsigned FLG_ACQ   = 3;
  localparam int unsigned FLG_EMPTY = 4;
  localparam int unsigned FLG_FULL  = 5;
  // status register positions
  localparam int unsigned STS_NEW   = 3;
  localparam int unsigned STS_EMPTY = 4;
  localparam int unsigned STS_FULL  = 5;
  localparam int unsigned STS_PEND  = 7;
  // enable register positions
  localparam int unsigned EN_WAKE_ACQ = 3;
  localparam int unsigned EN_EMPTY    = 4;
  localparam int unsigned EN_FULL     = 5;
endpackage

// File: rtl/sirq_edge_det.sv
module sirq_edge_det #(
  parameter int unsigned W = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/sirq_flag_bank.sv
module sirq_flag_bank #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] flags_o
);
  logic [W-1:0] flags_q;

  // set has priority over the clearing read
  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flags_q[b] <= 1'b0;
      else if (set_i[b])  flags_q[b] <= 1'b1;
      else if (clr_i)     flags_q[b] <= 1'b0;
    end
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/sirq_rd_mux.sv
module sirq_rd_mux #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] A_STAT = 8'h08,
  parameter logic [ADDR_W-1:0] A_FLAG = 8'h09,
  parameter logic [ADDR_W-1:0] A_EN   = 8'h17
) (
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [DATA_W-1:0] stat_i,
  input  logic [DATA_W-1:0] flag_i,
  input  logic [DATA_W-1:0] en_i,
  output logic [DATA_W-1:0] rd_data_o
);
  always_comb begin
    rd_data_o = '0;
    if (rd_en_i) begin
      unique case (rd_addr_i)
        A_STAT:  rd_data_o = stat_i;
        A_FLAG:  rd_data_o = flag_i;
        A_EN:    rd_data_o = en_i;
        default: rd_data_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/sensor_irq_ctrl.sv
module sensor_irq_ctrl
  import sirq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] A_STAT = 8'h08,
  parameter logic [ADDR_W-1:0] A_FLAG = 8'h09,
  parameter logic [ADDR_W-1:0] A_EN   = 8'h17,
  parameter bit PIN_EN = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_evt_i,
  input  logic              wake_evt_i,
  input  logic              fifo_empty_i,
  input  logic              fifo_full_i,
  input  logic [2:0]        mode_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              int_o
);
  localparam logic [DATA_W-1:0] EN_WMASK =
    DATA_W'((1 << EN_WAKE_ACQ) | (1 << EN_EMPTY) | (1 << EN_FULL));
  localparam int unsigned LVL_W = 2;
  localparam logic [LVL_W-1:0] LVL_RST = 2'b01; // {full, empty}: empty at reset

  logic rd_stat, rd_flag;
  logic [DATA_W-1:0] en_q, en_mask, set_vec, flags_q, stat_vec;
  logic [LVL_W-1:0] lvl_rise;
  logic new_data_q, mode_ok;

  assign rd_stat = rd_en_i && (rd_addr_i == A_STAT);
  assign rd_flag = rd_en_i && (rd_addr_i == A_FLAG);
  assign mode_ok = (mode_i == MODE_CWAKE) || (mode_i == MODE_TRIG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           en_q <= '0;
    else if (wr_en_i && wr_addr_i == A_EN) en_q <= wr_data_i & EN_WMASK;
  end

  sirq_edge_det #(.W(LVL_W), .RST_VAL(LVL_RST)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  ({fifo_full_i, fifo_empty_i}),
    .rise_o (lvl_rise)
  );

  always_comb begin
    en_mask            = '0;
    en_mask[FLG_WAKE]  = en_q[EN_WAKE_ACQ];
    en_mask[FLG_ACQ]   = en_q[EN_WAKE_ACQ];
    en_mask[FLG_EMPTY] = en_q[EN_EMPTY];
    en_mask[FLG_FULL]  = en_q[EN_FULL];
  end

  always_comb begin
    set_vec            = '0;
    set_vec[FLG_WAKE]  = wake_evt_i;
    set_vec[FLG_ACQ]   = sample_evt_i & mode_ok;
    set_vec[FLG_EMPTY] = lvl_rise[0];
    set_vec[FLG_FULL]  = lvl_rise[1];
    set_vec            = set_vec & en_mask;
  end

  sirq_flag_bank #(.W(DATA_W)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (set_vec),
    .clr_i   (rd_flag),
    .flags_o (flags_q)
  );

  logic [0:0] new_data_v;
  sirq_flag_bank #(.W(1)) u_new (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (sample_evt_i),
    .clr_i   (rd_stat),
    .flags_o (new_data_v)
  );
  assign new_data_q = new_data_v[0];

  always_comb begin
    stat_vec            = '0;
    stat_vec[STS_NEW]   = new_data_q;
    stat_vec[STS_EMPTY] = fifo_empty_i;
    stat_vec[STS_FULL]  = fifo_full_i;
    stat_vec[STS_PEND]  = |flags_q;
  end

  sirq_rd_mux #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .A_STAT(A_STAT), .A_FLAG(A_FLAG), .A_EN(A_EN)
  ) u_mux (
    .rd_en_i   (rd_en_i),
    .rd_addr_i (rd_addr_i),
    .stat_i    (stat_vec),
    .flag_i    (flags_q),
    .en_i      (en_q),
    .rd_data_o (rd_data_o)
  );

  if (PIN_EN) begin : g_pin
    logic int_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) int_q <= 1'b0;
      else         int_q <= |(flags_q & en_mask);
    end
    assign int_o = int_q;
  end else begin : g_nopin
    assign int_o = 1'b0;
  end
endmodule

// File: rtl/sirq_checker.sv
module sirq_checker #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] A_STAT = 8'h08,
  parameter logic [ADDR_W-1:0] A_FLAG = 8'h09,
  parameter bit PIN_EN = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sample_evt_i,
  input logic              fifo_empty_i,
  input logic              fifo_full_i,
  input logic [2:0]        mode_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              int_o,
  input logic [DATA_W-1:0] flags_q,
  input logic [DATA_W-1:0] set_vec,
  input logic [DATA_W-1:0] en_mask,
  input logic              new_data_q
);
  logic rd08, rd09;
  assign rd08 = rd_en_i && rd_addr_i == A_STAT;
  assign rd09 = rd_en_i && rd_addr_i == A_FLAG;

  assert_lvl_rd_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd08 |-> (rd_data_o[4] == fifo_empty_i && rd_data_o[5] == fifo_full_i));

  assert_new_clr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd08 && !sample_evt_i) |=> !new_data_q);

  assert_flag_clr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd09 |=> ((flags_q & ~$past(set_vec)) == '0));

  assert_mode_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_evt_i && !(mode_i == 3'd3 || mode_i == 3'd4) && !flags_q[3]) |=> !flags_q[3]);

  assert_empty_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_q[4]) |-> $past(fifo_empty_i));

  assert_full_rise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_q[5]) |-> $past(fifo_full_i));

  assert_set_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_vec) |=> ((flags_q & $past(set_vec)) == $past(set_vec)));

  if (PIN_EN) begin : g_pin_chk
    assert_pin_lag_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      int_o == $past(|(flags_q & en_mask)));
  end
endmodule

bind sensor_irq_ctrl sirq_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .A_STAT(A_STAT), .A_FLAG(A_FLAG), .PIN_EN(PIN_EN)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sample_evt_i (sample_evt_i),
  .fifo_empty_i (fifo_empty_i),
  .fifo_full_i  (fifo_full_i),
  .mode_i       (mode_i),
  .rd_en_i      (rd_en_i),
  .rd_addr_i    (rd_addr_i),
  .rd_data_o    (rd_data_o),
  .int_o        (int_o),
  .flags_q      (flags_q),
  .set_vec      (set_vec),
  .en_mask      (en_mask),
  .new_data_q   (new_data_q)
);

// File: tb/tb_sensor_irq_ctrl.sv
module tb_sensor_irq_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_evt = 0, wake_evt = 0, fifo_empty = 1, fifo_full = 0;
  logic [2:0] mode = 3'd1;
  logic rd_en = 0, wr_en = 0;
  logic [7:0] rd_addr = 0, wr_addr = 0, wr_data = 0, rd_data;
  logic int_pin;

  always #2.5 clk = ~clk; // 200 MHz

  sensor_irq_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n),
    .sample_evt_i(sample_evt), .wake_evt_i(wake_evt),
    .fifo_empty_i(fifo_empty), .fifo_full_i(fifo_full),
    .mode_i(mode),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .int_o(int_pin)
  );

  typedef struct {
    bit         is_pin;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t sb_q[$];
  int n_vec = 0, n_bad = 0;
  bit done = 0;

  // monitor: compare every queued expectation away from the active edge
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      item_t it;
      logic [7:0] got;
      it = sb_q.pop_front();
      got = it.is_pin ? {7'd0, int_pin} : rd_data;
      n_vec++;
      if (got !== it.exp) begin
        n_bad++;
        $display("FAIL %s got=%02h exp=%02h", it.tag, got, it.exp);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic rd_evt(input logic [7:0] a, input logic [7:0] e, input string t,
                        input bit s, input bit w);
    item_t it;
    rd_en = 1; rd_addr = a; sample_evt = s; wake_evt = w;
    it.is_pin = 0; it.exp = e; it.tag = t;
    sb_q.push_back(it);
    step();
    rd_en = 0; sample_evt = 0; wake_evt = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string t);
    rd_evt(a, e, t, 1'b0, 1'b0);
  endtask

  task automatic pin(input bit e, input string t);
    item_t it;
    it.is_pin = 1; it.exp = {7'd0, e}; it.tag = t;
    sb_q.push_back(it);
  endtask

  task automatic pulse(input bit s, input bit w);
    sample_evt = s; wake_evt = w;
    step();
    sample_evt = 0; wake_evt = 0;
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1; wr_addr = 8'h17; wr_data = d;
    step();
    wr_en = 0;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    step();
    // R1 reset state
    rd(8'h08, 8'h10, "R1 status");
    rd(8'h09, 8'h00, "R1 flags");
    rd(8'h17, 8'h00, "R1 enable");
    pin(0, "R1 pin");
    rd(8'h20, 8'h00, "R12 unmapped");
    // R2 writable mask
    wr(8'hFF);
    rd(8'h17, 8'h38, "R2 enable mask");
    // R4/R6 standby and sniff
    mode = 3'd1; pulse(1, 0);
    rd(8'h08, 8'h18, "R4 new data standby");
    rd(8'h09, 8'h00, "R6 no flag standby");
    rd(8'h08, 8'h10, "R4 new data cleared");
    mode = 3'd2; pulse(1, 0);
    rd(8'h09, 8'h00, "R6 no flag sniff");
    rd(8'h08, 8'h18, "R4 new data sniff");
    // R6/R11 continuous wake
    mode = 3'd3; pulse(1, 0);
    pin(0, "R11 pin lag rise");
    step();
    pin(1, "R11 pin high");
    rd(8'h08, 8'h98, "R3 pending set");
    rd(8'h09, 8'h08, "R5 sample flag");
    pin(1, "R11 pin lag fall");
    step();
    pin(0, "R11 pin low");
    rd(8'h09, 8'h00, "R5 cleared");
    rd(8'h08, 8'h10, "R3 pending clear");
    pulse(1, 0);
    rd(8'h09, 8'h08, "R6 first");
    pulse(1, 0);
    rd(8'h09, 8'h08, "R6 rearmed");
    rd(8'h08, 8'h18, "R4 sticky");
    mode = 3'd4; pulse(1, 0);
    rd(8'h09, 8'h08, "R6 trig");
    rd(8'h08, 8'h18, "R4 trig");
    mode = 3'd3;
    // R7 empty edge
    fifo_empty = 0; step(); step();
    rd(8'h09, 8'h00, "R7 fall no flag");
    rd(8'h08, 8'h00, "R3 empty low");
    fifo_empty = 1; step();
    rd(8'h09, 8'h10, "R7 empty rise");
    step();
    rd(8'h09, 8'h00, "R7 no refire");
    // R8 full edge
    fifo_empty = 0; fifo_full = 1; step();
    rd(8'h08, 8'hA0, "R3 full level");
    rd(8'h09, 8'h20, "R8 full rise");
    rd(8'h09, 8'h00, "R8 no refire");
    fifo_full = 0; step();
    fifo_full = 1; step();
    rd(8'h09, 8'h20, "R8 refire");
    fifo_full = 0; fifo_empty = 1; step();
    rd(8'h09, 8'h10, "R7 refire");
    // R9 wake
    pulse(0, 1);
    rd(8'h09, 8'h04, "R9 wake");
    pulse(1, 1);
    rd(8'h09, 8'h0C, "R9 wake and sample");
    rd(8'h08, 8'h18, "R4 after combo");
    // R10 set wins
    rd_evt(8'h09, 8'h00, "R10 read with sample", 1, 0);
    rd(8'h09, 8'h08, "R10 sample kept");
    rd_evt(8'h08, 8'h18, "R10 read08 with sample", 1, 0);
    rd(8'h08, 8'h98, "R10 new data kept");
    rd(8'h09, 8'h08, "R10 flag");
    rd(8'h08, 8'h10, "R4 cleared again");
    rd_evt(8'h09, 8'h00, "R10 read with wake", 0, 1);
    rd(8'h09, 8'h04, "R10 wake kept");
    // R2 disabled sources
    wr(8'h00);
    rd(8'h17, 8'h00, "R2 disabled");
    pulse(1, 0); pulse(0, 1);
    fifo_empty = 0; step();
    fifo_empty = 1; step();
    fifo_full = 1; step();
    rd(8'h09, 8'h00, "R2 no flags latched");
    rd(8'h08, 8'h38, "R4 ungated new data");
    fifo_full = 0; step();
    // R11 masking by enable
    wr(8'h38);
    pulse(0, 1);
    step();
    pin(1, "R11 enabled flag");
    wr(8'h00);
    pin(1, "R11 mask lag");
    step();
    pin(0, "R11 masked");
    rd(8'h08, 8'h90, "R3 pending while masked");
    rd(8'h09, 8'h04, "R11 flag kept");
    step();
    pin(0, "R11 low after clear");
    step();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule